// File: doc/BRIEF.md
# Receive Page Ring Manager

This block places incoming packet bytes into a circular receive area of local memory that is divided into fixed 256-byte pages. Software sets the ring bounds with a first-page input and a limit-page input. The limit page is exclusive: the ring covers pages from the first page up to, but not including, the limit page. The block keeps a current-page pointer, which is the page where the next packet will start. The host supplies a boundary page, which is the oldest page it has not yet consumed.

When a packet starts, data bytes are written from offset 4 of the current page onward. A packet longer than one page spills into the following pages, and the page after the last ring page is the first ring page again. When the packet ends and is accepted, the block writes a 4-byte header into the first four bytes of the packet's first page: receive status, next-page pointer, byte count low, byte count high. It then advances the current-page pointer to the next-page value. A rejected packet leaves the current-page pointer unchanged, so its pages are reused by the next packet. If the page about to be written is the boundary page, the block stops storing the packet and raises an overflow flag. It then waits for the end of that packet.

The state machine has four states:
- IDLE waits for `rx_start`. It goes to DATA, or to DROP when the current page equals the boundary page.
- DATA writes one byte per valid cycle. It goes to HDR on an accepted end, to IDLE on a rejected end, and to DROP when a byte would enter the boundary page.
- HDR writes the four header bytes on four consecutive cycles and then returns to IDLE.
- DROP discards input until `rx_end` and then returns to IDLE.

Top module: `rx_ring_mgr`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cur_pg` loads `cfg_first_pg`, `ring_ovf` clears and `mem_we` stays low.
- R2: In each cycle of a packet in which `rx_vld` is high, the byte is written combinationally on `mem_we`/`mem_addr`/`mem_wdata`. Address bits 15:8 are the page and bits 7:0 are the offset. The first data byte of a packet goes to offset 0x04 of `cur_pg`, and each later byte goes to the next address.
- R3: After a byte at offset 0xFF, the next byte goes to offset 0x00 of the following page. The page that follows `cfg_last_pg`-1 is `cfg_first_pg`.
- R4: On an accepted end (`rx_end` with `rx_good` high), the next four cycles write offsets 0x00..0x03 of the packet's first page with, in order: `rx_stat`, the next-page pointer, the data byte count bits 7:0, and the count bits 15:8. The count excludes the header.
- R5: The next-page pointer is the page following the one that holds the last data byte. If the last byte sat at offset 0xFF, it is the page after that, with wrap as in R3.
- R6: `cur_pg` takes the next-page pointer in the cycle after the last header write.
- R7: On a rejected end (`rx_end` with `rx_good` low), no header is written and `cur_pg` is unchanged, so the next packet starts at the same page.
- R8: A byte that would be written into a page equal to `host_bnd_pg` is not written. The same applies to every byte of a packet whose start finds `cur_pg` equal to `host_bnd_pg`. In either case `ring_ovf` is set, the rest of the packet is discarded without any write, no header is written and `cur_pg` is unchanged.
- R9: `ring_ovf` stays set until a later `rx_start` that does not itself overflow, which clears it.
- R10: No write ever targets a page outside the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_first_pg | input | PAGE_W | First page of the ring |
| cfg_last_pg | input | PAGE_W | Exclusive upper page limit of the ring |
| host_bnd_pg | input | PAGE_W | Oldest page still held by the host |
| rx_start | input | 1 | Packet start strobe |
| rx_vld | input | 1 | Data byte valid |
| rx_data | input | 8 | Data byte |
| rx_end | input | 1 | Packet end strobe |
| rx_good | input | 1 | Packet accepted, valid with `rx_end` |
| rx_stat | input | 8 | Receive status byte, valid with `rx_end` |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | PAGE_W+8 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| cur_pg | output | PAGE_W | Page where the next packet starts |
| ring_ovf | output | 1 | Overflow flag |

## Verification
The assertions assume a legal environment:
- `cfg_first_pg` is below `cfg_last_pg`, and both stay stable after reset.
- `host_bnd_pg` lies inside the ring and changes only while no packet is in progress.
- `rx_start` arrives only in IDLE, and `rx_vld` never coincides with `rx_start` or `rx_end`.

The directed stimulus respects all of this. It programs a six-page ring once before reset. It moves the boundary only between packets, and it drives the strobes one per cycle with a gap after each header.

// File: rtl/rx_ring_pkg.sv
package rx_ring_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_HDR,
        ST_DROP
    } ring_st_e;

    localparam int HDR_LEN = 4;
    localparam int BYTE_W  = 8;
endpackage

// File: rtl/rx_ring_page_adv.sv
module rx_ring_page_adv #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] pg_in,
    input  logic [PAGE_W-1:0] first_pg,
    input  logic [PAGE_W-1:0] last_pg,
    output logic [PAGE_W-1:0] pg_out
);
    logic [PAGE_W-1:0] inc;

    always_comb begin
        inc    = pg_in + 1'b1;
        pg_out = (inc == last_pg) ? first_pg : inc;
    end
endmodule

// File: rtl/rx_ring_hdr_mux.sv
module rx_ring_hdr_mux #(
    parameter int PAGE_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        stat,
    input  logic [PAGE_W-1:0] nxt_pg,
    input  logic [15:0]       len,
    output logic [7:0]        hbyte
);
    always_comb begin
        unique case (idx)
            2'd0:    hbyte = stat;
            2'd1:    hbyte = 8'(nxt_pg);
            2'd2:    hbyte = len[7:0];
            default: hbyte = len[15:8];
        endcase
    end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
    import rx_ring_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PAGE_W-1:0]   cfg_first_pg,
    input  logic [PAGE_W-1:0]   cfg_last_pg,
    input  logic [PAGE_W-1:0]   host_bnd_pg,
    input  logic                rx_start,
    input  logic                rx_vld,
    input  logic [7:0]          rx_data,
    input  logic                rx_end,
    input  logic                rx_good,
    input  logic [7:0]          rx_stat,
    output logic                mem_we,
    output logic [PAGE_W+7:0]   mem_addr,
    output logic [7:0]          mem_wdata,
    output logic [PAGE_W-1:0]   cur_pg,
    output logic                ring_ovf
);
    localparam int OFF_W  = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int IDX_W  = $clog2(HDR_LEN);

    ring_st_e            state_q, state_d;
    logic [PAGE_W-1:0]   cur_q, pg_q, nxt_q, pg_adv;
    logic [OFF_W-1:0]    off_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [IDX_W-1:0]    hidx_q;
    logic [7:0]          stat_q, hbyte;
    logic                ovf_q;
    logic                start_full, data_hit;

    rx_ring_page_adv #(.PAGE_W(PAGE_W)) u_adv (
        .pg_in    (pg_q),
        .first_pg (cfg_first_pg),
        .last_pg  (cfg_last_pg),
        .pg_out   (pg_adv)
    );

    rx_ring_hdr_mux #(.PAGE_W(PAGE_W), .IDX_W(IDX_W)) u_hdr (
        .idx    (hidx_q),
        .stat   (stat_q),
        .nxt_pg (nxt_q),
        .len    (cnt_q),
        .hbyte  (hbyte)
    );

    assign start_full = (cur_q == host_bnd_pg);
    assign data_hit   = (off_q == '0) && (pg_q == host_bnd_pg);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (rx_start) state_d = start_full ? ST_DROP : ST_DATA;
            ST_DATA: begin
                if (rx_end)                  state_d = rx_good ? ST_HDR : ST_IDLE;
                else if (rx_vld && data_hit) state_d = ST_DROP;
            end
            ST_HDR:  if (hidx_q == IDX_W'(HDR_LEN - 1)) state_d = ST_IDLE;
            ST_DROP: if (rx_end) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= cfg_first_pg;
            pg_q   <= '0;
            off_q  <= '0;
            cnt_q  <= '0;
            hidx_q <= '0;
            nxt_q  <= '0;
            stat_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (rx_start) begin
                        ovf_q <= start_full;
                        pg_q  <= cur_q;
                        off_q <= OFF_W'(HDR_LEN);
                        cnt_q <= '0;
                    end
                end
                ST_DATA: begin
                    if (rx_end) begin
                        stat_q <= rx_stat;
                        nxt_q  <= (off_q == '0) ? pg_q : pg_adv;
                        hidx_q <= '0;
                    end else if (rx_vld) begin
                        if (data_hit) begin
                            ovf_q <= 1'b1;
                        end else begin
                            off_q <= off_q + 1'b1;
                            cnt_q <= cnt_q + 1'b1;
                            if (off_q == '1) pg_q <= pg_adv;
                        end
                    end
                end
                ST_HDR: begin
                    hidx_q <= hidx_q + 1'b1;
                    if (hidx_q == IDX_W'(HDR_LEN - 1)) cur_q <= nxt_q;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_we    = 1'b0;
        mem_addr  = {pg_q, off_q};
        mem_wdata = rx_data;
        unique case (state_q)
            ST_DATA: mem_we = rx_vld && !rx_end && !data_hit;
            ST_HDR: begin
                mem_we    = 1'b1;
                mem_addr  = {cur_q, OFF_W'(hidx_q)};
                mem_wdata = hbyte;
            end
            default: ;
        endcase
        cur_pg   = cur_q;
        ring_ovf = ovf_q;
    end
endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk
    import rx_ring_pkg::*;
#(
    parameter int PAGE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PAGE_W-1:0] cfg_first_pg,
    input logic [PAGE_W-1:0] cfg_last_pg,
    input logic [PAGE_W-1:0] host_bnd_pg,
    input logic              mem_we,
    input logic [PAGE_W+7:0] mem_addr,
    input logic [PAGE_W-1:0] cur_pg,
    input logic              ring_ovf,
    input ring_st_e          st
);
    logic [PAGE_W-1:0] wpg;
    assign wpg = mem_addr[PAGE_W+7:8];

    AST_WR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wpg >= cfg_first_pg && wpg < cfg_last_pg)); // R10
    AST_WR_NOT_BND: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (wpg != host_bnd_pg)); // R8
    AST_OVF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ring_ovf |-> !mem_we); // R8
    AST_CUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_HDR) |=> $stable(cur_pg)); // R7
    AST_HDR_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HDR) |-> mem_we); // R4
    AST_CUR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_pg >= cfg_first_pg && cur_pg < cfg_last_pg)); // R6
endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(.PAGE_W(PAGE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_first_pg (cfg_first_pg),
    .cfg_last_pg  (cfg_last_pg),
    .host_bnd_pg  (host_bnd_pg),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .cur_pg       (cur_pg),
    .ring_ovf     (ring_ovf),
    .st           (state_q)
);

// File: tb/rx_ring_mgr_bench.sv
module rx_ring_mgr_bench;
    localparam logic [7:0] PFIRST = 8'h40;
    localparam logic [7:0] PLAST  = 8'h46;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_first_pg = PFIRST, cfg_last_pg = PLAST, host_bnd_pg = 8'h45;
    logic        rx_start = 0, rx_vld = 0, rx_end = 0, rx_good = 0;
    logic [7:0]  rx_data = 0, rx_stat = 0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_pg;
    logic        ring_ovf;

    int n_chk = 0, n_bad = 0;
    logic [7:0] mcur;

    always #5 clk = ~clk;

    rx_ring_mgr u_rx_ring_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_first_pg(cfg_first_pg), .cfg_last_pg(cfg_last_pg),
        .host_bnd_pg(host_bnd_pg), .rx_start(rx_start), .rx_vld(rx_vld), .rx_data(rx_data),
        .rx_end(rx_end), .rx_good(rx_good), .rx_stat(rx_stat), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_pg(cur_pg), .ring_ovf(ring_ovf)
    );

    function automatic logic [7:0] adv(input logic [7:0] p);
        return (p + 8'd1 == PLAST) ? PFIRST : p + 8'd1;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drives one packet and checks every write against the requirement model
    task automatic run_pkt(input int n, input bit good, input logic [7:0] st);
        bit drop;
        logic [7:0] pg, off, nx, e;
        logic [15:0] cnt;
        @(negedge clk);
        rx_start = 1;
        #2 chk(mem_we == 0, "R2 idle", 32'(mem_we), 0);
        drop = (mcur == host_bnd_pg);
        @(negedge clk);
        rx_start = 0;
        pg = mcur; off = 8'h04; cnt = 0;
        for (int i = 0; i < n; i++) begin
            rx_vld = 1; rx_data = 8'(i * 7 + 3);
            #2;
            if (!drop && off == 8'h00 && pg == host_bnd_pg) drop = 1;
            if (drop) chk(mem_we == 0, "R8 write blocked", 32'(mem_we), 0);
            else begin
                chk(mem_we && mem_addr == {pg, off} && mem_wdata == rx_data, "R2/R3 data write",
                    {7'd0, mem_we, mem_addr, mem_wdata}, {7'd0, 1'b1, pg, off, rx_data});
                if (off == 8'hFF) pg = adv(pg);
                off++; cnt++;
            end
            @(negedge clk);
        end
        rx_vld = 0; rx_end = 1; rx_good = good; rx_stat = st;
        #2 chk(mem_we == 0, "R4 end cycle", 32'(mem_we), 0);
        @(negedge clk);
        rx_end = 0; rx_good = 0;
        if (good && !drop) begin
            nx = (off == 8'h00) ? pg : adv(pg);
            for (int k = 0; k < 4; k++) begin
                #2;
                e = (k == 0) ? st : (k == 1) ? nx : (k == 2) ? cnt[7:0] : cnt[15:8];
                chk(mem_we && mem_addr == {mcur, 8'(k)} && mem_wdata == e, "R4/R5 header",
                    {7'd0, mem_we, mem_addr, mem_wdata}, {7'd0, 1'b1, mcur, 8'(k), e});
                @(negedge clk);
            end
            #2 chk(cur_pg == nx, "R6 cur advance", 32'(cur_pg), 32'(nx));
            mcur = nx;
        end else begin
            #2 chk(mem_we == 0, "R7/R8 no header", 32'(mem_we), 0);
            chk(cur_pg == mcur, "R7/R8 cur held", 32'(cur_pg), 32'(mcur));
        end
        chk(ring_ovf == drop, "R8/R9 ovf flag", 32'(ring_ovf), 32'(drop));
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2 chk(cur_pg == PFIRST, "R1 cur", 32'(cur_pg), 32'(PFIRST));
        chk(ring_ovf == 0, "R1 ovf", 32'(ring_ovf), 0);
        chk(mem_we == 0, "R1 we", 32'(mem_we), 0);
        mcur = PFIRST;
    endtask

    task automatic t_short;      // R2 R4 R6
        run_pkt(10, 1, 8'h21);
        chk(cur_pg == 8'h41, "R6 short", 32'(cur_pg), 32'h41);
    endtask

    task automatic t_reject;     // R7
        run_pkt(5, 0, 8'h00);
        chk(cur_pg == 8'h41, "R7 reject", 32'(cur_pg), 32'h41);
    endtask

    task automatic t_multi;      // R3 R5
        run_pkt(300, 1, 8'h01);
        chk(cur_pg == 8'h43, "R5 multi", 32'(cur_pg), 32'h43);
    endtask

    task automatic t_overflow;   // R8
        run_pkt(600, 1, 8'h01);
        chk(ring_ovf == 1, "R8 ovf set", 32'(ring_ovf), 1);
        chk(cur_pg == 8'h43, "R8 cur held", 32'(cur_pg), 32'h43);
    endtask

    task automatic t_wrap;       // R3 R9
        @(negedge clk); host_bnd_pg = 8'h42;
        run_pkt(600, 1, 8'h05);
        chk(ring_ovf == 0, "R9 ovf cleared", 32'(ring_ovf), 0);
        chk(cur_pg == 8'h40, "R3 wrap", 32'(cur_pg), 32'h40);
    endtask

    task automatic t_exact;      // R5 last byte at 0xFF
        run_pkt(252, 1, 8'h07);
        chk(cur_pg == 8'h41, "R5 exact fill", 32'(cur_pg), 32'h41);
    endtask

    task automatic t_start_full; // R8 R9
        @(negedge clk); host_bnd_pg = 8'h41;
        run_pkt(8, 1, 8'h01);
        chk(ring_ovf == 1, "R8 start full", 32'(ring_ovf), 1);
        @(negedge clk); host_bnd_pg = 8'h40;
        run_pkt(10, 1, 8'h02);
        chk(ring_ovf == 0, "R9 recover", 32'(ring_ovf), 0);
        chk(cur_pg == 8'h42, "R6 recover", 32'(cur_pg), 32'h42);
    endtask

    initial begin
        t_reset;
        t_short;
        t_reject;
        t_multi;
        t_overflow;
        t_wrap;
        t_exact;
        t_start_full;
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule